// File: doc/BRIEF.md
# I2C Event Interrupt and Vector Unit

This unit sits between the bus engine of an I2C master controller and its register interface. The engine sends one-cycle pulses when one of five things happens: arbitration is lost, the target does not acknowledge, a programmed access completes, a received byte is waiting, or the transmitter wants a byte. Each pulse sets a sticky flag. Two more sticky flags record a receive overrun and a transmit underflow. A live bus-busy level is also shown.

Software sees three word offsets. The status word holds the flags, and a flag is cleared by writing a one to it. The mask word enables the five event flags onto a single interrupt line. The vector word is read-only and returns a small code for the enabled event that matters most. Reading the vector also clears the flag it reports, so a simple handler can loop on the vector alone. Read data is combinational from the current offset. All state changes take effect on the clock edge that samples a strobe or a pulse.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: After reset the status word, the mask word, the vector word and the interrupt line all read zero.
- R2: An event pulse sets its status bit one cycle later, and the bit stays set until it is cleared. The bit positions are: arbitration lost at bit 0, no acknowledge at bit 1, access ready at bit 2, receive ready at bit 3, transmit ready at bit 4. The status word is at offset 0.
- R3: A write to offset 0 clears every sticky status bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R4: A write to offset 1 stores write-data bits 4..0 as the mask, using the same positions as the status word. Reading offset 1 returns the mask in bits 4..0 and zero in all other bits.
- R5: The interrupt line is high exactly while some status bit 4..0 is set and its mask bit is also set.
- R6: Reading offset 2 returns the code of the lowest-numbered enabled pending event: 1 arbitration lost, 2 no acknowledge, 3 access ready, 4 receive ready, 5 transmit ready. It returns 0 when no enabled event is pending. Offset 3 reads zero.
- R7: A read of offset 2 that returns a nonzero code clears the status bit of that event only.
- R8: Status bit 12 follows the bus-busy input directly. Writes have no effect on it, and it never raises the interrupt line.
- R9: If an event pulse arrives in the same cycle as a clear of that bit, either by a write or by a vector read, the bit stays set.
- R10: A transmit-underflow pulse sets bit 10 and a receive-overrun pulse sets bit 11. Both bits are sticky and cleared by writing 1, and neither drives the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_arb_lost_i | input | 1 | Pulse: arbitration lost |
| evt_nack_i | input | 1 | Pulse: no acknowledge received |
| evt_acc_rdy_i | input | 1 | Pulse: programmed access complete |
| evt_rx_rdy_i | input | 1 | Pulse: receive byte available |
| evt_tx_rdy_i | input | 1 | Pulse: transmitter needs a byte |
| tx_udf_i | input | 1 | Pulse: transmit underflow |
| rx_ovr_i | input | 1 | Pulse: receive overrun |
| bus_busy_i | input | 1 | Live bus-busy level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Word offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the current offset |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle and that each strobe lasts one cycle per access. The vector clear depends on this, because a held read strobe would clear one event per cycle. The bench drives every access as a single-cycle strobe with inputs changed on the falling edge. It never raises a read and a write together. The only overlaps it creates on purpose are an event pulse together with a strobe, which are the cases named in R9.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    localparam int REG_W   = 16;
    localparam int EVT_N   = 5;
    localparam int CODE_W  = $clog2(EVT_N + 1);

    // status bit positions
    localparam int POS_UDF  = 10;
    localparam int POS_OVR  = 11;
    localparam int POS_BUSY = 12;

    // register word offsets
    localparam int OFF_STAT = 0;
    localparam int OFF_MASK = 1;
    localparam int OFF_VEC  = 2;

    typedef enum logic [CODE_W-1:0] {
        VEC_NONE = 3'd0,
        VEC_ARB  = 3'd1,
        VEC_NACK = 3'd2,
        VEC_ACC  = 3'd3,
        VEC_RX   = 3'd4,
        VEC_TX   = 3'd5
    } vec_code_e;

    // bits that hold sticky state and accept write-one-to-clear
    function automatic logic [REG_W-1:0] sticky_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[EVT_N-1:0] = '1;
        m[POS_UDF]   = 1'b1;
        m[POS_OVR]   = 1'b1;
        return m;
    endfunction

    // lowest-numbered pending event wins
    function automatic vec_code_e prio_code(input logic [EVT_N-1:0] pend);
        vec_code_e c;
        c = VEC_NONE;
        for (int i = EVT_N - 1; i >= 0; i--) begin
            if (pend[i]) c = vec_code_e'(CODE_W'(i + 1));
        end
        return c;
    endfunction

    function automatic logic [EVT_N-1:0] code_onehot(input vec_code_e c);
        logic [EVT_N-1:0] oh;
        oh = '0;
        for (int i = 0; i < EVT_N; i++) begin
            if (int'(c) == i + 1) oh[i] = 1'b1;
        end
        return oh;
    endfunction

endpackage

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
    import i2c_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             udf_i,
    input  logic             ovr_i,
    input  logic             busy_i,
    input  logic             wr_clr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [EVT_N-1:0] vec_clr_i,
    output logic [REG_W-1:0] stat_o,
    output logic [EVT_N-1:0] evt_q_o
);

    localparam logic [REG_W-1:0] STICKY = sticky_mask();

    logic [REG_W-1:0] sticky_q;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[EVT_N-1:0] = evt_i;
        set_vec[POS_UDF]   = udf_i;
        set_vec[POS_OVR]   = ovr_i;
    end

    always_comb begin
        clr_vec = wr_clr_i ? (wdata_i & STICKY) : '0;
        clr_vec[EVT_N-1:0] = clr_vec[EVT_N-1:0] | vec_clr_i;
    end

    // a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst) sticky_q <= '0;
        else     sticky_q <= (sticky_q & ~clr_vec) | set_vec;
    end

    always_comb begin
        stat_o = sticky_q;
        stat_o[POS_BUSY] = busy_i;
    end

    assign evt_q_o = sticky_q[EVT_N-1:0];

    for (genvar k = 0; k < EVT_N; k++) begin : g_chk
        AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
            evt_i[k] |=> sticky_q[k]);                                   // R9
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (wr_clr_i && wdata_i[k] && !evt_i[k]) |=> !sticky_q[k]);    // R3
        AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!(wr_clr_i && wdata_i[k]) && !vec_clr_i[k] && !evt_i[k])
            |=> (sticky_q[k] == $past(sticky_q[k])));                    // R3
    end

    AST_OVR_STICKS: assert property (@(posedge clk) disable iff (rst)
        ovr_i |=> stat_o[POS_OVR]);                                      // R10

endmodule

// File: rtl/i2c_evt_mask.sv
module i2c_evt_mask
    import i2c_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [EVT_N-1:0] wdata_i,
    output logic [EVT_N-1:0] en_o
);

    always_ff @(posedge clk) begin
        if (rst)       en_o <= '0;
        else if (wr_i) en_o <= wdata_i;
    end

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (en_o == $past(wdata_i)));                              // R4
    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(en_o));                                        // R4

endmodule

// File: rtl/i2c_evt_vector.sv
module i2c_evt_vector
    import i2c_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] evt_q_i,
    input  logic [EVT_N-1:0] en_i,
    input  logic             rd_i,
    output vec_code_e        code_o,
    output logic [EVT_N-1:0] clr_o,
    output logic             irq_o
);

    logic [EVT_N-1:0] pend;

    assign pend   = evt_q_i & en_i;
    assign irq_o  = |pend;
    assign code_o = prio_code(pend);
    assign clr_o  = rd_i ? code_onehot(code_o) : '0;

    AST_CODE_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (code_o != VEC_NONE) |-> irq_o);                                 // R6
    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_o));                                                // R7
    AST_CLEAR_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
        ((clr_o & ~pend) == '0));                                        // R7

endmodule

// File: rtl/i2c_evt_irq_unit.sv
module i2c_evt_irq_unit
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_arb_lost_i,
    input  logic              evt_nack_i,
    input  logic              evt_acc_rdy_i,
    input  logic              evt_rx_rdy_i,
    input  logic              evt_tx_rdy_i,
    input  logic              tx_udf_i,
    input  logic              rx_ovr_i,
    input  logic              bus_busy_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFF_VEC);

    logic [EVT_N-1:0] evt_pulse;
    logic [EVT_N-1:0] evt_q;
    logic [EVT_N-1:0] en_q;
    logic [EVT_N-1:0] vec_clr;
    logic [REG_W-1:0] stat_view;
    vec_code_e        code;
    logic             wr_stat, wr_mask, rd_vec;

    assign evt_pulse = {evt_tx_rdy_i, evt_rx_rdy_i, evt_acc_rdy_i,
                        evt_nack_i, evt_arb_lost_i};

    assign wr_stat = reg_wr_i && (reg_addr_i == A_STAT);
    assign wr_mask = reg_wr_i && (reg_addr_i == A_MASK);
    assign rd_vec  = reg_rd_i && (reg_addr_i == A_VEC);

    i2c_evt_status u_status (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_pulse),
        .udf_i     (tx_udf_i),
        .ovr_i     (rx_ovr_i),
        .busy_i    (bus_busy_i),
        .wr_clr_i  (wr_stat),
        .wdata_i   (reg_wdata_i),
        .vec_clr_i (vec_clr),
        .stat_o    (stat_view),
        .evt_q_o   (evt_q)
    );

    i2c_evt_mask u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_mask),
        .wdata_i (reg_wdata_i[EVT_N-1:0]),
        .en_o    (en_q)
    );

    i2c_evt_vector u_vector (
        .clk     (clk),
        .rst     (rst),
        .evt_q_i (evt_q),
        .en_i    (en_q),
        .rd_i    (rd_vec),
        .code_o  (code),
        .clr_o   (vec_clr),
        .irq_o   (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_STAT:  reg_rdata_o = stat_view;
            A_MASK:  reg_rdata_o[EVT_N-1:0] = en_q;
            A_VEC:   reg_rdata_o[CODE_W-1:0] = code;
            default: reg_rdata_o = '0;
        endcase
    end

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_i && reg_rd_i));                                        // R3
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (evt_q == '0) |-> !irq_o);                                       // R8
    AST_VEC_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_vec && code == VEC_ARB && !evt_arb_lost_i) |=> !evt_q[0]);   // R7

endmodule

// File: tb/tb_i2c_evt_irq_unit.sv
module tb_i2c_evt_irq_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  ev = '0;
    logic        udf = 1'b0, ovr = 1'b0, busy = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_evt_irq_unit #(.ADDR_W(2)) dut (
        .clk(clk), .rst(rst),
        .evt_arb_lost_i(ev[0]), .evt_nack_i(ev[1]), .evt_acc_rdy_i(ev[2]),
        .evt_rx_rdy_i(ev[3]), .evt_tx_rdy_i(ev[4]),
        .tx_udf_i(udf), .rx_ovr_i(ovr), .bus_busy_i(busy),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    // fields: [13:9] events, [8:4] mask, [3:1] expected code, [0] expected irq
    localparam logic [13:0] TBL [10] = '{
        {5'b00001, 5'b11111, 3'd1, 1'b1},
        {5'b00010, 5'b11111, 3'd2, 1'b1},
        {5'b00100, 5'b11111, 3'd3, 1'b1},
        {5'b01000, 5'b11111, 3'd4, 1'b1},
        {5'b10000, 5'b11111, 3'd5, 1'b1},
        {5'b11110, 5'b11111, 3'd2, 1'b1},
        {5'b11000, 5'b11111, 3'd4, 1'b1},
        {5'b10000, 5'b01111, 3'd0, 1'b0},
        {5'b00011, 5'b00010, 3'd2, 1'b1},
        {5'b00000, 5'b11111, 3'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] e);
        @(negedge clk); ev = e;
        @(negedge clk); ev = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1 chk("R1 irq", irq, 0);
        rd_reg(0, d); chk("R1 status", d, 0);
        rd_reg(1, d); chk("R1 mask", d, 0);
        rd_reg(2, d); chk("R1 vector", d, 0);

        // table walk: R2, R5, R6
        foreach (TBL[i]) begin
            wr_reg(0, 16'h1C1F);
            wr_reg(1, {11'd0, TBL[i][8:4]});
            pulse(TBL[i][13:9]);
            #1 chk("R5 irq", irq, TBL[i][0]);
            rd_reg(0, d); chk("R2 status", d, {11'd0, TBL[i][13:9]});
            rd_reg(2, d); chk("R6 vector", d, {13'd0, TBL[i][3:1]});
        end

        // R4 mask width
        wr_reg(1, 16'hFFFF);
        rd_reg(1, d); chk("R4 mask", d, 16'h001F);
        rd_reg(3, d); chk("R6 offset3", d, 0);

        // R3 partial clear, zero write holds
        wr_reg(0, 16'h1C1F);
        pulse(5'b11111);
        wr_reg(0, 16'h0005);
        rd_reg(0, d); chk("R3 partial", d, 16'h001A);
        wr_reg(0, 16'h0000);
        rd_reg(0, d); chk("R3 zero", d, 16'h001A);

        // R7 vector drain in priority order
        wr_reg(0, 16'h1C1F);
        pulse(5'b11111);
        for (int k = 1; k <= 5; k++) begin
            rd_reg(2, d); chk("R7 drain", d, k);
        end
        rd_reg(2, d); chk("R7 empty", d, 0);
        #1 chk("R7 irq", irq, 0);

        // R9 write clear and pulse together
        @(negedge clk); ev = 5'b00010; wr = 1'b1; addr = 0; wdata = 16'h0002;
        @(negedge clk); ev = '0; wr = 1'b0; wdata = '0;
        rd_reg(0, d); chk("R9 write", d, 16'h0002);
        wr_reg(0, 16'h1C1F);

        // R9 vector read and pulse together
        pulse(5'b00001);
        @(negedge clk); ev = 5'b00001; rd = 1'b1; addr = 2;
        #1 chk("R9 code", rdata, 1);
        @(negedge clk); ev = '0; rd = 1'b0;
        rd_reg(2, d); chk("R9 read", d, 1);
        rd_reg(2, d); chk("R7 cleared", d, 0);

        // R8 bus busy
        @(negedge clk); busy = 1'b1;
        rd_reg(0, d); chk("R8 live", d, 16'h1000);
        wr_reg(0, 16'h1000);
        rd_reg(0, d); chk("R8 write", d, 16'h1000);
        #1 chk("R8 irq", irq, 0);
        @(negedge clk); busy = 1'b0;
        rd_reg(0, d); chk("R8 drop", d, 0);

        // R10 overrun and underflow
        @(negedge clk); udf = 1'b1; ovr = 1'b1;
        @(negedge clk); udf = 1'b0; ovr = 1'b0;
        #1 chk("R10 irq", irq, 0);
        rd_reg(0, d); chk("R10 set", d, 16'h0C00);
        wr_reg(0, 16'h0400);
        rd_reg(0, d); chk("R10 clear", d, 16'h0800);

        // R1 reset again clears everything
        pulse(5'b10101);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_reg(0, d); chk("R1 re-status", d, 0);
        rd_reg(1, d); chk("R1 re-mask", d, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule